// File: doc/BRIEF.md
# Machine-Mode Trap Entry Controller

This block sits beside a hart's pipeline and performs the state update for trap entry in one step. When the pipeline presents a trap (a cause code and a flag that says whether the event is asynchronous), the block picks one of four outcomes: enter a resumable non-maskable interrupt (NMI) handler, enter the ordinary machine trap handler, send a machine-mode double trap into the NMI handler, or declare the double trap fatal. It then updates the machine status fields it owns, the trap and NMI cause registers and the saved NMI PC. It also drives the PC, privilege and virtualization state the hart continues with.

Two configuration inputs turn the resumable-NMI path and machine double-trap detection on or off. A third input enables forward-edge landing-pad tracking, so that the expected-landing-pad flag is saved on NMI entry. Some interrupt-enable, double-trap and NMI-enable bits are normally changed by software and by return instructions. A separate load strobe lets the surrounding CSR file write those bits when no trap is being taken.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After synchronous reset: NMI-enable = 1, double-trap bit = 0, MIE = 0, MPIE = 0, MPP = 00, all cause and saved-PC registers = 0, next PC = 0, next privilege = machine (privilege encoding: 00 user, 01 supervisor, 11 machine), virtualization = 0, abort = 0.
- R2: A trap with `trap_async`=1 while `nmi_pending`=1 and `cfg_nmi_en`=1 takes NMI entry ahead of every other outcome. NMI-enable is cleared. The saved virtualization bit gets `cur_virt` and the saved privilege gets `cur_priv`. `mncause` = {1, cause} with the 1 at bit XLEN-1, and `mnepc` = `cur_pc`. The next PC becomes the NMI interrupt vector. The machine status fields and `mcause` do not change.
- R3: On any NMI entry, the saved landing-pad bit takes `elp_expected` if `lp_enable`=1. Otherwise it keeps its value.
- R4: Ordinary entry copies MIE into MPIE, writes `cur_priv` into MPP and clears MIE. It writes `mcause` = {`trap_async`, cause} and leaves the NMI registers unchanged.
- R5: Ordinary entry sets the double-trap bit when `cfg_dbltrp_en`=1 and leaves it unchanged when that input is 0.
- R6: The next PC after ordinary entry is the NMI exception vector when `cfg_nmi_en`=1, NMI-enable=0 and the trap is synchronous. In every other case it is the ordinary trap vector.
- R7: A trap that is not an R2 NMI, taken with `cfg_dbltrp_en`=1 and the double-trap bit already 1, goes to NMI entry when `cfg_nmi_en`=1 and it is not a synchronous trap with NMI-enable=0. In that case `mncause` = {0, cause}, the saved virtualization bit is 0, the other NMI entry effects of R2 apply, and the machine status fields and `mcause` do not change.
- R8: The same double trap as in R7, when `cfg_nmi_en`=0 or when it is a synchronous trap with NMI-enable=0, raises `dbl_abort` and changes no other state. Such a trap only arises in machine mode (`cur_priv`=11).
- R9: Once raised, `dbl_abort` stays 1 until reset. While it is 1, traps and load strobes change nothing.
- R10: Every trap that is not fatal leaves next privilege = 11 and virtualization = 0. A cycle with `trap_valid`=0 and `st_load`=0 changes no output.
- R11: With `trap_valid`=0, `st_load`=1 writes `st_mie`, `st_mdt` and `st_nmie` into MIE, the double-trap bit and NMI-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_async | input | 1 | The trap is an interrupt (1) or an exception (0) |
| trap_cause | input | XLEN-1 | Cause code without the interrupt bit |
| nmi_pending | input | 1 | A resumable NMI is pending |
| cur_priv | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| cur_virt | input | 1 | Current virtualization flag |
| cur_pc | input | XLEN | PC of the trapping instruction |
| lp_enable | input | 1 | Forward-edge landing-pad tracking enabled |
| elp_expected | input | 1 | A landing pad is currently expected |
| cfg_nmi_en | input | 1 | Resumable NMI support present |
| cfg_dbltrp_en | input | 1 | Machine double-trap detection present |
| st_load | input | 1 | Load the three writable status bits |
| st_mie | input | 1 | Value for MIE |
| st_mdt | input | 1 | Value for the double-trap bit |
| st_nmie | input | 1 | Value for NMI-enable |
| next_pc | output | XLEN | PC to continue from |
| next_priv | output | 2 | Privilege to continue in |
| next_virt | output | 1 | Virtualization flag to continue with |
| dbl_abort | output | 1 | Fatal double trap, sticky |
| mst_mie | output | 1 | Machine interrupt enable |
| mst_mpie | output | 1 | Previous interrupt enable |
| mst_mpp | output | 2 | Previous privilege |
| mst_mdt | output | 1 | Machine double-trap bit |
| mcause | output | XLEN | Machine trap cause |
| mns_nmie | output | 1 | NMI enable |
| mns_mnpv | output | 1 | Saved virtualization on NMI |
| mns_mnpp | output | 2 | Saved privilege on NMI |
| mns_mnpelp | output | 1 | Saved expected-landing-pad flag on NMI |
| mncause | output | XLEN | NMI cause |
| mnepc | output | XLEN | Saved PC on NMI |

## Verification
The bench builds the block with XLEN = 32 and three distinct, explicitly passed vectors, so that each possible next PC can be told apart. For every case it starts from reset, loads one combination of MIE, double-trap bit and NMI-enable, and then applies one trap. The sweep is complete over both configuration enables, those three bits, the asynchronous and pending flags, the three privileges, the virtualization flag, the landing-pad inputs and whether landing-pad tracking is on. This reaches all four outcomes, including both conditions that make a double trap fatal. After each fatal case, further traps and loads probe the sticky abort.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_NORMAL = 2'd1,
        ACT_NMI    = 2'd2,
        ACT_ABORT  = 2'd3
    } act_e;

    typedef struct packed {
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
        logic       mdt;
    } mstat_t;

    typedef struct packed {
        logic       nmie;
        logic       mnpv;
        logic [1:0] mnpp;
        logic       mnpelp;
    } mnstat_t;

    typedef struct packed {
        act_e act;
        logic cause_msb;
        logic nmi_virt;
        logic exc_vec;
    } decision_t;

    function automatic logic nmi_takes_priority(input logic nmi_en, input logic pend,
                                                input logic async_evt);
        return nmi_en & pend & async_evt;
    endfunction

endpackage

// File: rtl/trap_classify.sv
module trap_classify
    import trap_entry_pkg::*;
(
    input  logic      trap_valid,
    input  logic      abort_q,
    input  logic      trap_async,
    input  logic      nmi_pending,
    input  logic      cfg_nmi_en,
    input  logic      cfg_dbltrp_en,
    input  logic      mdt,
    input  logic      nmie,
    input  logic      cur_virt,
    output decision_t dec
);
    logic nmi_take;
    logic inside_nmi_exc;
    logic dbl_hit;

    assign nmi_take       = nmi_takes_priority(cfg_nmi_en, nmi_pending, trap_async);
    assign inside_nmi_exc = cfg_nmi_en & ~nmie & ~trap_async;
    assign dbl_hit        = cfg_dbltrp_en & mdt;

    always_comb begin
        dec = '0;
        dec.act = ACT_NONE;
        if (trap_valid && !abort_q) begin
            if (nmi_take) begin
                dec.act       = ACT_NMI;
                dec.cause_msb = 1'b1;
                dec.nmi_virt  = cur_virt;
            end else if (dbl_hit) begin
                if (!cfg_nmi_en || inside_nmi_exc) begin
                    dec.act = ACT_ABORT;
                end else begin
                    dec.act       = ACT_NMI;
                    dec.cause_msb = 1'b0;
                    dec.nmi_virt  = 1'b0;
                end
            end else begin
                dec.act       = ACT_NORMAL;
                dec.cause_msb = trap_async;
                dec.exc_vec   = inside_nmi_exc;
            end
        end
    end
endmodule

// File: rtl/mstate_regs.sv
module mstate_regs
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  act_e            act,
    input  logic            cause_msb,
    input  logic [XLEN-2:0] cause,
    input  logic [1:0]      cur_priv,
    input  logic            cfg_dbltrp_en,
    input  logic            load_en,
    input  logic            ld_mie,
    input  logic            ld_mdt,
    output mstat_t          mst,
    output logic [XLEN-1:0] mcause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mst    <= '{mie: 1'b0, mpie: 1'b0, mpp: 2'b00, mdt: 1'b0};
            mcause <= '0;
        end else if (act == ACT_NORMAL) begin
            mst.mpie <= mst.mie;
            mst.mpp  <= cur_priv;
            mst.mie  <= 1'b0;
            if (cfg_dbltrp_en) begin
                mst.mdt <= 1'b1;
            end
            mcause <= {cause_msb, cause};
        end else if (load_en) begin
            mst.mie <= ld_mie;
            mst.mdt <= ld_mdt;
        end
    end
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  act_e            act,
    input  logic            cause_msb,
    input  logic            nmi_virt,
    input  logic [XLEN-2:0] cause,
    input  logic [1:0]      cur_priv,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            lp_enable,
    input  logic            elp_expected,
    input  logic            load_en,
    input  logic            ld_nmie,
    output mnstat_t         mns,
    output logic [XLEN-1:0] mncause,
    output logic [XLEN-1:0] mnepc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mns     <= '{nmie: 1'b1, mnpv: 1'b0, mnpp: 2'b00, mnpelp: 1'b0};
            mncause <= '0;
            mnepc   <= '0;
        end else if (act == ACT_NMI) begin
            mns.nmie <= 1'b0;
            mns.mnpv <= nmi_virt;
            mns.mnpp <= cur_priv;
            if (lp_enable) begin
                mns.mnpelp <= elp_expected;
            end
            mncause <= {cause_msb, cause};
            mnepc   <= cur_pc;
        end else if (load_en) begin
            mns.nmie <= ld_nmie;
        end
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter logic [63:0] TRAP_VEC    = 64'h0000_0100,
    parameter logic [63:0] NMI_INT_VEC = 64'h0000_01C0,
    parameter logic [63:0] NMI_EXC_VEC = 64'h0000_01E0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_valid,
    input  logic            trap_async,
    input  logic [XLEN-2:0] trap_cause,
    input  logic            nmi_pending,
    input  logic [1:0]      cur_priv,
    input  logic            cur_virt,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            lp_enable,
    input  logic            elp_expected,
    input  logic            cfg_nmi_en,
    input  logic            cfg_dbltrp_en,
    input  logic            st_load,
    input  logic            st_mie,
    input  logic            st_mdt,
    input  logic            st_nmie,
    output logic [XLEN-1:0] next_pc,
    output logic [1:0]      next_priv,
    output logic            next_virt,
    output logic            dbl_abort,
    output logic            mst_mie,
    output logic            mst_mpie,
    output logic [1:0]      mst_mpp,
    output logic            mst_mdt,
    output logic [XLEN-1:0] mcause,
    output logic            mns_nmie,
    output logic            mns_mnpv,
    output logic [1:0]      mns_mnpp,
    output logic            mns_mnpelp,
    output logic [XLEN-1:0] mncause,
    output logic [XLEN-1:0] mnepc
);
    localparam logic [XLEN-1:0] VEC_TRAP = TRAP_VEC[XLEN-1:0];
    localparam logic [XLEN-1:0] VEC_NINT = NMI_INT_VEC[XLEN-1:0];
    localparam logic [XLEN-1:0] VEC_NEXC = NMI_EXC_VEC[XLEN-1:0];

    decision_t       dec;
    mstat_t          mst;
    mnstat_t         mns;
    logic            abort_q;
    logic            load_en;
    logic [XLEN-1:0] pc_q;
    priv_e           priv_q;
    logic            virt_q;

    assign load_en = st_load & ~trap_valid & ~abort_q;

    trap_classify u_classify (
        .trap_valid    (trap_valid),
        .abort_q       (abort_q),
        .trap_async    (trap_async),
        .nmi_pending   (nmi_pending),
        .cfg_nmi_en    (cfg_nmi_en),
        .cfg_dbltrp_en (cfg_dbltrp_en),
        .mdt           (mst.mdt),
        .nmie          (mns.nmie),
        .cur_virt      (cur_virt),
        .dec           (dec)
    );

    mstate_regs #(.XLEN(XLEN)) u_mstate (
        .clk           (clk),
        .rst           (rst),
        .act           (dec.act),
        .cause_msb     (dec.cause_msb),
        .cause         (trap_cause),
        .cur_priv      (cur_priv),
        .cfg_dbltrp_en (cfg_dbltrp_en),
        .load_en       (load_en),
        .ld_mie        (st_mie),
        .ld_mdt        (st_mdt),
        .mst           (mst),
        .mcause        (mcause)
    );

    nmi_regs #(.XLEN(XLEN)) u_nmi (
        .clk          (clk),
        .rst          (rst),
        .act          (dec.act),
        .cause_msb    (dec.cause_msb),
        .nmi_virt     (dec.nmi_virt),
        .cause        (trap_cause),
        .cur_priv     (cur_priv),
        .cur_pc       (cur_pc),
        .lp_enable    (lp_enable),
        .elp_expected (elp_expected),
        .load_en      (load_en),
        .ld_nmie      (st_nmie),
        .mns          (mns),
        .mncause      (mncause),
        .mnepc        (mnepc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            priv_q  <= PRIV_M;
            virt_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            case (dec.act)
                ACT_NMI: begin
                    pc_q   <= VEC_NINT;
                    priv_q <= PRIV_M;
                    virt_q <= 1'b0;
                end
                ACT_NORMAL: begin
                    pc_q   <= dec.exc_vec ? VEC_NEXC : VEC_TRAP;
                    priv_q <= PRIV_M;
                    virt_q <= 1'b0;
                end
                ACT_ABORT: abort_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign next_pc    = pc_q;
    assign next_priv  = priv_q;
    assign next_virt  = virt_q;
    assign dbl_abort  = abort_q;
    assign mst_mie    = mst.mie;
    assign mst_mpie   = mst.mpie;
    assign mst_mpp    = mst.mpp;
    assign mst_mdt    = mst.mdt;
    assign mns_nmie   = mns.nmie;
    assign mns_mnpv   = mns.mnpv;
    assign mns_mnpp   = mns.mnpp;
    assign mns_mnpelp = mns.mnpelp;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int          XLEN        = 32,
    parameter logic [63:0] NMI_INT_VEC = 64'h0000_01C0
) (
    input logic            clk,
    input logic            rst,
    input logic            trap_valid,
    input logic            trap_async,
    input logic            nmi_pending,
    input logic [1:0]      cur_priv,
    input logic            cur_virt,
    input logic [XLEN-1:0] cur_pc,
    input logic            cfg_nmi_en,
    input logic            cfg_dbltrp_en,
    input logic [XLEN-1:0] next_pc,
    input logic [1:0]      next_priv,
    input logic            next_virt,
    input logic            dbl_abort,
    input logic            mst_mie,
    input logic            mst_mpie,
    input logic            mst_mdt,
    input logic [XLEN-1:0] mcause,
    input logic            mns_nmie,
    input logic            mns_mnpv,
    input logic [XLEN-1:0] mncause,
    input logic [XLEN-1:0] mnepc
);
    logic take_nmi;
    logic dbl_seen;
    logic go_normal;
    logic fatal_cond;

    assign take_nmi   = trap_valid && !dbl_abort && cfg_nmi_en && nmi_pending && trap_async;
    assign dbl_seen   = trap_valid && !dbl_abort && !take_nmi && cfg_dbltrp_en && mst_mdt;
    assign go_normal  = trap_valid && !dbl_abort && !take_nmi && !(cfg_dbltrp_en && mst_mdt);
    assign fatal_cond = !cfg_nmi_en || (!trap_async && !mns_nmie);

    p_nmi_entry_r2: assert property (@(posedge clk) disable iff (rst)
        take_nmi |=> !mns_nmie && mncause[XLEN-1] && mnepc == $past(cur_pc)
                     && mns_mnpv == $past(cur_virt) && next_pc == NMI_INT_VEC[XLEN-1:0]);

    p_normal_entry_r4: assert property (@(posedge clk) disable iff (rst)
        go_normal |=> !mst_mie && mst_mpie == $past(mst_mie)
                      && mcause[XLEN-1] == $past(trap_async));

    p_mdt_set_r5: assert property (@(posedge clk) disable iff (rst)
        go_normal && cfg_dbltrp_en |=> mst_mdt);

    p_dbl_to_nmi_r7: assert property (@(posedge clk) disable iff (rst)
        dbl_seen && !fatal_cond |=> !mncause[XLEN-1] && !mns_mnpv && !mns_nmie
                                    && $stable(mst_mie) && $stable(mcause));

    p_dbl_fatal_r8: assert property (@(posedge clk) disable iff (rst)
        dbl_seen && fatal_cond |=> dbl_abort && $stable(mcause) && $stable(mnepc)
                                   && $stable(mns_nmie) && $stable(mst_mie));

    p_dbl_in_m_r8: assert property (@(posedge clk) disable iff (rst)
        dbl_seen |-> cur_priv == 2'b11);

    p_abort_hold_r9: assert property (@(posedge clk) disable iff (rst)
        dbl_abort |=> dbl_abort && $stable(mcause) && $stable(mncause)
                      && $stable(mst_mdt) && $stable(mns_nmie) && $stable(next_pc));

    p_priv_m_r10: assert property (@(posedge clk) disable iff (rst)
        (take_nmi || go_normal) |=> next_priv == 2'b11 && !next_virt);
endmodule

bind trap_entry_ctrl trap_entry_chk #(
    .XLEN        (XLEN),
    .NMI_INT_VEC (NMI_INT_VEC)
) i_trap_entry_chk (
    .clk           (clk),
    .rst           (rst),
    .trap_valid    (trap_valid),
    .trap_async    (trap_async),
    .nmi_pending   (nmi_pending),
    .cur_priv      (cur_priv),
    .cur_virt      (cur_virt),
    .cur_pc        (cur_pc),
    .cfg_nmi_en    (cfg_nmi_en),
    .cfg_dbltrp_en (cfg_dbltrp_en),
    .next_pc       (next_pc),
    .next_priv     (next_priv),
    .next_virt     (next_virt),
    .dbl_abort     (dbl_abort),
    .mst_mie       (mst_mie),
    .mst_mpie      (mst_mpie),
    .mst_mdt       (mst_mdt),
    .mcause        (mcause),
    .mns_nmie      (mns_nmie),
    .mns_mnpv      (mns_mnpv),
    .mncause       (mncause),
    .mnepc         (mnepc)
);

// File: tb/test_trap_entry_ctrl.sv
module test_trap_entry_ctrl;
    localparam int          XL       = 32;
    localparam int          CLK_PER  = 10;
    localparam logic [63:0] V_TRAP   = 64'h0000_0100;
    localparam logic [63:0] V_NINT   = 64'h0000_01C0;
    localparam logic [63:0] V_NEXC   = 64'h0000_01E0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trap_valid = 0, trap_async = 0, nmi_pending = 0;
    logic [XL-2:0] trap_cause = '0;
    logic [1:0]    cur_priv = 2'b11;
    logic          cur_virt = 0, lp_enable = 0, elp_expected = 0;
    logic [XL-1:0] cur_pc = '0;
    logic          cfg_nmi_en = 0, cfg_dbltrp_en = 0;
    logic          st_load = 0, st_mie = 0, st_mdt = 0, st_nmie = 0;
    logic [XL-1:0] next_pc, mcause, mncause, mnepc;
    logic [1:0]    next_priv, mst_mpp, mns_mnpp;
    logic          next_virt, dbl_abort, mst_mie, mst_mpie, mst_mdt;
    logic          mns_nmie, mns_mnpv, mns_mnpelp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PER/2) clk = ~clk;

    trap_entry_ctrl #(
        .XLEN(XL), .TRAP_VEC(V_TRAP), .NMI_INT_VEC(V_NINT), .NMI_EXC_VEC(V_NEXC)
    ) i_trap_entry_ctrl (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_async(trap_async),
        .trap_cause(trap_cause), .nmi_pending(nmi_pending), .cur_priv(cur_priv),
        .cur_virt(cur_virt), .cur_pc(cur_pc), .lp_enable(lp_enable),
        .elp_expected(elp_expected), .cfg_nmi_en(cfg_nmi_en), .cfg_dbltrp_en(cfg_dbltrp_en),
        .st_load(st_load), .st_mie(st_mie), .st_mdt(st_mdt), .st_nmie(st_nmie),
        .next_pc(next_pc), .next_priv(next_priv), .next_virt(next_virt),
        .dbl_abort(dbl_abort), .mst_mie(mst_mie), .mst_mpie(mst_mpie), .mst_mpp(mst_mpp),
        .mst_mdt(mst_mdt), .mcause(mcause), .mns_nmie(mns_nmie), .mns_mnpv(mns_mnpv),
        .mns_mnpp(mns_mnpp), .mns_mnpelp(mns_mnpelp), .mncause(mncause), .mnepc(mnepc)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // expected state, updated arithmetically from the requirements
    logic          e_mie, e_mpie, e_mdt, e_nmie, e_mnpv, e_mnpelp, e_virt, e_abort;
    logic [1:0]    e_mpp, e_mnpp, e_priv;
    logic [XL-1:0] e_mcause, e_mncause, e_mnepc, e_pc;

    task automatic check_all(input string tag);
        check({tag, " mstatus"}, {e_mie, e_mpie, e_mpp}, {mst_mie, mst_mpie, mst_mpp});
        check("R5 mdt", 64'(mst_mdt), 64'(e_mdt));
        check({tag, " mcause"}, mcause, e_mcause);
        check({tag, " mnstatus"}, {mns_nmie, mns_mnpv, mns_mnpp}, {e_nmie, e_mnpv, e_mnpp});
        check("R3 mnpelp", 64'(mns_mnpelp), 64'(e_mnpelp));
        check({tag, " mncause"}, mncause, e_mncause);
        check({tag, " mnepc"}, mnepc, e_mnepc);
        check("R6 next_pc", next_pc, e_pc);
        check("R10 priv/virt", {next_priv, next_virt}, {e_priv, e_virt});
        check("R8 abort", 64'(dbl_abort), 64'(e_abort));
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        e_mie = 0; e_mpie = 0; e_mpp = 2'b00; e_mdt = 0; e_mcause = '0;
        e_nmie = 1; e_mnpv = 0; e_mnpp = 2'b00; e_mnpelp = 0; e_mncause = '0; e_mnepc = '0;
        e_pc = '0; e_priv = 2'b11; e_virt = 0; e_abort = 0;
    endtask

    initial begin
        string tag;
        logic nmi_take, fatal;
        for (int idx = 0; idx < 3072; idx++) begin
            logic c_nmi, c_dbl, l_mie, l_mdt, l_nmie, a_async, a_pend, a_virt, a_elp, a_lp;
            logic [1:0] a_priv;
            int q;
            c_nmi = idx[0]; c_dbl = idx[1]; l_mie = idx[2]; l_mdt = idx[3];
            l_nmie = idx[4]; a_async = idx[5]; a_pend = idx[6];
            q = idx >> 7;
            a_priv = (q % 3 == 0) ? 2'b00 : (q % 3 == 1) ? 2'b01 : 2'b11;
            a_virt = (q / 3) % 2 == 1;
            a_elp  = (q / 6) % 2 == 1;
            a_lp   = (q / 12) % 2 == 1;
            nmi_take = c_nmi && a_pend && a_async;
            // a double trap only happens in machine mode
            if (c_dbl && l_mdt && !nmi_take && a_priv != 2'b11) continue;

            do_reset();
            if (idx == 0) check_all("R1");

            // R11: load the writable bits
            cfg_nmi_en = c_nmi; cfg_dbltrp_en = c_dbl;
            @(negedge clk);
            st_load = 1; st_mie = l_mie; st_mdt = l_mdt; st_nmie = l_nmie;
            @(negedge clk);
            st_load = 0;
            e_mie = l_mie; e_mdt = l_mdt; e_nmie = l_nmie;
            check("R11 load", {mst_mie, mst_mdt, mns_nmie}, {e_mie, e_mdt, e_nmie});

            // the trap
            trap_valid = 1; trap_async = a_async; nmi_pending = a_pend;
            trap_cause = 31'((idx * 13 + 3) & 32'h7FFF_FFFF);
            cur_priv = a_priv; cur_virt = a_virt; elp_expected = a_elp; lp_enable = a_lp;
            cur_pc = 32'h8000_0000 + 32'(idx * 4);
            @(negedge clk);
            trap_valid = 0;

            fatal = 0;
            if (nmi_take || (c_dbl && l_mdt && !(!c_nmi || (!a_async && !l_nmie)))) begin
                tag = nmi_take ? "R2" : "R7";
                e_nmie = 0; e_mnpv = nmi_take ? a_virt : 1'b0; e_mnpp = a_priv;
                if (a_lp) e_mnpelp = a_elp;
                e_mncause = {nmi_take, trap_cause}; e_mnepc = cur_pc;
                e_pc = V_NINT[XL-1:0]; e_priv = 2'b11; e_virt = 0;
            end else if (c_dbl && l_mdt) begin
                tag = "R8"; fatal = 1; e_abort = 1;
            end else begin
                tag = "R4";
                e_mpie = e_mie; e_mpp = a_priv; e_mie = 0;
                if (c_dbl) e_mdt = 1;
                e_mcause = {a_async, trap_cause};
                e_pc = (c_nmi && !l_nmie && !a_async) ? V_NEXC[XL-1:0] : V_TRAP[XL-1:0];
                e_priv = 2'b11; e_virt = 0;
            end
            check_all(tag);

            // R10: an idle cycle with changed inputs leaves everything alone
            trap_cause = ~trap_cause; cur_pc = ~cur_pc; cur_priv = 2'b01; cur_virt = ~cur_virt;
            @(negedge clk);
            check_all("R10 idle");

            if (fatal) begin
                // R9: further traps and loads are ignored after an abort
                trap_valid = 1; trap_async = 0; nmi_pending = 0; cur_priv = 2'b11;
                st_load = 1; st_mie = 1; st_mdt = 0; st_nmie = 1;
                @(negedge clk);
                trap_valid = 0;
                @(negedge clk);
                st_load = 0;
                check_all("R9 sticky");
            end
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1-R11 run incomplete got=timeout exp=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule